// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a small synchronous up-counter with a parallel preset path, two count-enable inputs and a carry output meant for chaining stages into wider counters. An active-low clear has top priority, an active-low load copies the preset word into the count, and the counter advances only when both enables are high. Otherwise the count holds.

A single parameter picks the clear style. The asynchronous variant zeroes the count the moment the clear input falls. The synchronous variant zeroes it on the next rising clock edge.

The carry output is high when the count sits at its all-ones value and the T enable is high. It follows the T enable without waiting for a clock edge. To build a wider counter, feed each stage's carry into the T enable of the stage above it and share the P enable and the clock across all stages.

Top module: `presettable_counter`

## Requirements
- R1: While clr_n is low at a rising clock edge, the count becomes 0 whatever ld_n, en_p and en_t are; clear beats load, and load beats counting.
- R2: With ASYNC_CLR=1 the count becomes 0 as soon as clr_n falls, with no clock edge needed.
- R3: With ASYNC_CLR=0 a falling clr_n leaves the count unchanged until the next rising clock edge, which then clears it.
- R4: When clr_n is high and ld_n is low, a rising edge copies preset into the count, whatever the enables are.
- R5: When clr_n and ld_n are high and en_p and en_t are both high, each rising edge adds one to the count.
- R6: When clr_n and ld_n are high and either en_p or en_t is low, the count holds its value.
- R7: rco is high exactly when the count is all ones (15 for WIDTH=4) and en_t is high. It follows en_t combinationally, and en_p has no effect on it.
- R8: Incrementing from all ones wraps the count to 0.
- R9: In a two-stage cascade, with the low stage's rco driving the high stage's en_t and en_p shared, the pair counts as one 8-bit synchronous counter.
- R10: With ASYNC_CLR=1, the first rising edge after clr_n goes high loads or counts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear (async or sync per ASYNC_CLR) |
| ld_n | input | 1 | Active-low parallel load |
| en_p | input | 1 | Count enable, does not affect carry |
| en_t | input | 1 | Count enable, also gates carry |
| preset | input | WIDTH | Parallel preset word |
| q | output | WIDTH | Current count |
| rco | output | 1 | Ripple carry for cascading |

## Verification
Assertions check on every active cycle that the load lands the preset word, that a count step adds one modulo the width (which covers the wrap), that the count holds when an enable is low, and that the carry never rises unless en_t is high and the count is all ones. Several behaviours can only be shown by the bench's scenarios:
- the clear timing of each variant between clock edges,
- the clean first edge after an asynchronous clear is released,
- the combinational response of the carry to en_t,
- the combined 8-bit sequence of a cascaded pair across the low stage's rollover.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import ctr_pkg::*;
(
  input  logic    clr_n,
  input  logic    ld_n,
  input  logic    en_p,
  input  logic    en_t,
  output ctr_op_e op
);
  // Fixed priority: clear, then load, then count, else hold
  always_comb begin
    if (!clr_n)             op = OP_CLEAR;
    else if (!ld_n)         op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_next_state.sv
module ctr_next_state
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = preset;
      OP_COUNT: nxt = cur + ONE;   // natural wrap at all ones
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_t,
  output logic             rco
);
  // Combinational from en_t so a cascade settles within one cycle
  assign rco = en_t & (&cur);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  ctr_op_e          op;
  logic [WIDTH-1:0] nxt;

  ctr_op_decode u_dec (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .op    (op)
  );

  ctr_next_state #(.WIDTH(WIDTH)) u_next (
    .op     (op),
    .cur    (q),
    .preset (preset),
    .nxt    (nxt)
  );

  ctr_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .q     (q)
  );

  ctr_carry #(.WIDTH(WIDTH)) u_carry (
    .cur  (q),
    .en_t (en_t),
    .rco  (rco)
  );

  AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> (q == $past(preset)));                                    // R4

  AST_COUNT_STEPS_ONE: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_p && en_t) |=> (q == WIDTH'($past(q) + 1'b1)));         // R5

  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_p && en_t)) |=> $stable(q));                          // R6

  AST_CARRY_QUALIFIED: assert property (@(posedge clk) disable iff (!clr_n)
    rco |-> (en_t && (q == ALL_ONES)));                                 // R7
endmodule

// File: tb/presettable_counter_tb.sv
module presettable_counter_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks   = 0;
  int failures = 0;

  // Shared stimulus for the sync (u_dut) and async (u_async) stages
  logic       clr_n = 1'b0, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] preset = 4'h0;
  logic [3:0] q_s, q_a;
  logic       rco_s, rco_a;

  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .preset(preset), .q(q_s), .rco(rco_s));

  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_async (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .preset(preset), .q(q_a), .rco(rco_a));

  // Two-stage cascade
  logic       c_clr_n = 1'b0, c_ld_n = 1'b1, c_ep = 1'b0;
  logic [7:0] c_pre = 8'h00;
  logic [3:0] q_lo, q_hi;
  logic       rco_lo, rco_hi;

  presettable_counter #(.WIDTH(4)) u_lo (
    .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .en_p(c_ep), .en_t(1'b1),
    .preset(c_pre[3:0]), .q(q_lo), .rco(rco_lo));

  presettable_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .en_p(c_ep), .en_t(rco_lo),
    .preset(c_pre[7:4]), .q(q_hi), .rco(rco_hi));

  // Vector: [16:13] req, [12] clr_n, [11] ld_n, [10] en_p, [9] en_t,
  //         [8:5] preset, [4:1] expected q, [0] expected rco (u_dut)
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {4'd4, 1'b1, 1'b0, 1'b1, 1'b1, 4'hE, 4'hE, 1'b0},  // R4 load
    {4'd5, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'hF, 1'b1},  // R5 count
    {4'd7, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 4'hF, 1'b1},  // R7 en_p low, carry stays
    {4'd6, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 4'hF, 1'b0},  // R6 en_t low holds
    {4'd8, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0},  // R8 wrap
    {4'd5, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'h1, 1'b0},  // R5
    {4'd4, 1'b1, 1'b0, 1'b0, 1'b0, 4'h5, 4'h5, 1'b0},  // R4 load ignores enables
    {4'd1, 1'b0, 1'b0, 1'b1, 1'b1, 4'hA, 4'h0, 1'b0},  // R1 clear beats load
    {4'd5, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'h1, 1'b0},  // R5
    {4'd4, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 4'hF, 1'b0},  // R4
    {4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 4'hF, 1'b1},  // R6 en_p low holds
    {4'd8, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0}   // R8 wrap
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edge_settle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    edge_settle();
    edge_settle();
    chk("R1 reset q sync",  {4'h0, q_s}, 8'h00);
    chk("R1 reset q async", {4'h0, q_a}, 8'h00);
    chk("R1 reset rco",     {7'h0, rco_s}, 8'h00);
    clr_n   = 1'b1;
    c_clr_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {clr_n, ld_n, en_p, en_t, preset} = VEC[i][12:5];
      edge_settle();
      chk($sformatf("R%0d vec%0d q",   VEC[i][16:13], i), {4'h0, q_s},   {4'h0, VEC[i][4:1]});
      chk($sformatf("R%0d vec%0d rco", VEC[i][16:13], i), {7'h0, rco_s}, {7'h0, VEC[i][0]});
    end

    // R7: carry follows en_t without a clock edge
    ld_n = 1'b0; preset = 4'hF; en_p = 1'b0; en_t = 1'b0;
    edge_settle();
    ld_n = 1'b1;
    #1 chk("R7 rco low with en_t low", {7'h0, rco_s}, 8'h00);
    en_t = 1'b1;
    #1 chk("R7 rco rises with en_t", {7'h0, rco_s}, 8'h01);

    // R2 / R3: clear timing of each variant between edges
    ld_n = 1'b0; preset = 4'h9; en_t = 1'b0;
    edge_settle();
    ld_n = 1'b1;
    clr_n = 1'b0;
    #1;
    chk("R2 async clears at once", {4'h0, q_a}, 8'h00);
    chk("R3 sync waits for edge",  {4'h0, q_s}, 8'h09);
    edge_settle();
    chk("R3 sync clears on edge",  {4'h0, q_s}, 8'h00);

    // R10: first edge after async release loads then counts
    clr_n = 1'b1; ld_n = 1'b0; preset = 4'h6;
    edge_settle();
    chk("R10 async first edge load", {4'h0, q_a}, 8'h06);
    ld_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    edge_settle();
    chk("R10 async counts next", {4'h0, q_a}, 8'h07);

    // R9: cascade across low-stage rollover
    c_ld_n = 1'b0; c_pre = 8'h3E; c_ep = 1'b1;
    edge_settle();
    chk("R9 cascade load", {q_hi, q_lo}, 8'h3E);
    c_ld_n = 1'b1;
    edge_settle();
    chk("R9 cascade 3F", {q_hi, q_lo}, 8'h3F);
    chk("R9 low carry at F", {7'h0, rco_lo}, 8'h01);
    edge_settle();
    chk("R9 cascade 40", {q_hi, q_lo}, 8'h40);
    edge_settle();
    chk("R9 cascade 41", {q_hi, q_lo}, 8'h41);
    c_ep = 1'b0;
    edge_settle();
    chk("R9 cascade holds", {q_hi, q_lo}, 8'h41);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule